// File: doc/BRIEF.md
# Brake-Throttle Plausibility Trip Monitor

This block is a synchronous safety monitor. It watches four digital indications from the vehicle's sensor front end: a hard-braking flag, a flag that the throttle is open past its threshold, and one "signal present" flag each for the brake and throttle sensors. It drives a single active-high enable for the shutdown path. The enable closes the path only after a short settle window following power-on, and only when the sensors look healthy at that point.

The block times three fault conditions separately, each with a counter that restarts whenever its condition goes away:

- hard braking together with open throttle, for longer than one second;
- loss of the brake sensor signal, for longer than 100 ms;
- loss of the throttle sensor signal, for longer than 100 ms.

When any of these runs past its limit, a sticky trip is latched and the enable falls. Inputs that later return to normal do not clear the trip. Only a power-on reset clears it.

A two-bit cause code records which condition tripped first. It is frozen for as long as the trip is held. All durations are parameters in milliseconds, converted to clock cycles from the clock frequency parameter.

Top module: `bpt_monitor`

## Requirements
- R1: When hard braking and open throttle are both present for more than OVERLAP_MS (more than OVL_LIM consecutive synchronised cycles), the block trips. An overlap of exactly OVL_LIM cycles or fewer does not trip.
- R2: When the brake-present flag is low for more than LOSS_MS (more than LOSS_LIM consecutive synchronised cycles), the block trips. A loss of LOSS_LIM cycles or fewer does not trip.
- R3: When the throttle-present flag is low for more than LOSS_LIM consecutive synchronised cycles, the block trips. A loss of LOSS_LIM cycles or fewer does not trip.
- R4: A trip drives shutdown_en to 0, which opens the shutdown path.
- R5: Once a trip occurs, shutdown_en stays 0 even after all inputs return to healthy. Only asserting rst_n low clears the trip.
- R6: shutdown_en is 0 during reset and for the first SETTLE (16) clock cycles after reset. After that window it goes to 1 only once none of the three conditions is present.
- R7: trip_cause reads 3 while no trip has occurred. On the first trip it takes one of these values: 0 for the overlap condition, 1 for brake signal loss, 2 for throttle signal loss. When conditions trip in the same cycle, the lowest code wins. The value then holds until reset, even if other conditions later run past their limits.
- R8: Each duration counter restarts from zero when its condition is absent for even one synchronised cycle. Interrupted conditions therefore never add up toward a trip.
- R9: Every input passes through a two-flop synchroniser before it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset; the only way to clear a trip |
| hard_brake | input | 1 | High while hard braking is detected |
| throttle_open | input | 1 | High while the throttle is open past its threshold |
| brake_present | input | 1 | High while the brake sensor signal is valid |
| throttle_present | input | 1 | High while the throttle sensor signal is valid |
| shutdown_en | output | 1 | High closes the shutdown path; low opens it |
| trip_cause | output | 2 | First trip cause: 0 overlap, 1 brake loss, 2 throttle loss, 3 none |

## Verification
The bound checker checks these properties on every cycle:

- any condition counter that reaches its limit while the condition is still present drops the enable on the next cycle;
- a latched cause always coincides with an open path;
- the cause code never changes once set;
- the enable stays low until the settle window ends.

Some behaviours only the bench scenarios can show:

- the exact boundary between a limit-length condition and one a cycle longer;
- that an interrupted overlap never trips;
- that a trip survives recovered inputs and clears only on reset;
- that a sensor lost at power-up keeps the path open;
- which cause wins when two losses start together.

// File: rtl/bpt_monitor.sv
`timescale 1ns/1ps
module bpt_monitor #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int OVERLAP_MS = 1000,
  parameter int LOSS_MS    = 100,
  parameter int SETTLE     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hard_brake,
  input  logic       throttle_open,
  input  logic       brake_present,
  input  logic       throttle_present,
  output logic       shutdown_en,
  output logic [1:0] trip_cause
);
  localparam int OVL_LIM  = CLK_HZ / 1000 * OVERLAP_MS;
  localparam int LOSS_LIM = CLK_HZ / 1000 * LOSS_MS;
  localparam int OW = $clog2(OVL_LIM + 1);
  localparam int LW = $clog2(LOSS_LIM + 1);
  localparam int SW = $clog2(SETTLE);

  logic [3:0] sync1, sync2;
  logic [OW-1:0] ovl_cnt;
  logic [LW-1:0] bl_cnt, tl_cnt;
  logic [SW-1:0] settle_cnt;
  logic tripped, ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {throttle_present, brake_present, throttle_open, hard_brake};
      sync2 <= sync1;
    end

  wire ovl_cond = sync2[0] & sync2[1];
  wire bl_cond  = ~sync2[2];
  wire tl_cond  = ~sync2[3];
  wire any_cond = ovl_cond | bl_cond | tl_cond;

  wire ovl_hit = ovl_cond && (ovl_cnt == OW'(OVL_LIM));
  wire bl_hit  = bl_cond  && (bl_cnt  == LW'(LOSS_LIM));
  wire tl_hit  = tl_cond  && (tl_cnt  == LW'(LOSS_LIM));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovl_cnt <= '0;
      bl_cnt  <= '0;
      tl_cnt  <= '0;
    end else begin
      if (!ovl_cond) ovl_cnt <= '0;
      else if (!ovl_hit) ovl_cnt <= ovl_cnt + 1'b1;
      if (!bl_cond) bl_cnt <= '0;
      else if (!bl_hit) bl_cnt <= bl_cnt + 1'b1;
      if (!tl_cond) tl_cnt <= '0;
      else if (!tl_hit) tl_cnt <= tl_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tripped    <= 1'b0;
      trip_cause <= 2'd3;
    end else if (!tripped && (ovl_hit || bl_hit || tl_hit)) begin
      tripped    <= 1'b1;
      trip_cause <= ovl_hit ? 2'd0 : (bl_hit ? 2'd1 : 2'd2);
    end

  wire settle_done = (settle_cnt == SW'(SETTLE - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      settle_cnt <= '0;
      ready      <= 1'b0;
    end else begin
      if (!settle_done) settle_cnt <= settle_cnt + 1'b1;
      if (settle_done && !any_cond) ready <= 1'b1;
    end

  assign shutdown_en = ready & ~tripped;
endmodule

module bpt_monitor_chk #(
  parameter int OW = 4,
  parameter int LW = 4,
  parameter int SW = 4,
  parameter int OVL_LIM = 10,
  parameter int LOSS_LIM = 5,
  parameter int SETTLE = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shutdown_en,
  input logic [1:0]    trip_cause,
  input logic [OW-1:0] ovl_cnt,
  input logic [LW-1:0] bl_cnt,
  input logic [LW-1:0] tl_cnt,
  input logic          ovl_cond,
  input logic          bl_cond,
  input logic          tl_cond,
  input logic [SW-1:0] settle_cnt
);
  AST_OVERLAP_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_cond && ovl_cnt == OW'(OVL_LIM)) |=> !shutdown_en); // R1
  AST_BRAKE_LOSS_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_cond && bl_cnt == LW'(LOSS_LIM)) |=> !shutdown_en); // R2
  AST_THROTTLE_LOSS_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tl_cond && tl_cnt == LW'(LOSS_LIM)) |=> !shutdown_en); // R3
  AST_CAUSE_OPENS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cause != 2'd3) |-> !shutdown_en); // R4
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cause != 2'd3) |=> (trip_cause != 2'd3 && !shutdown_en)); // R5
  AST_SETTLE_HOLDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_cnt != SW'(SETTLE - 1)) |-> !shutdown_en); // R6
  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cause != 2'd3) |=> $stable(trip_cause)); // R7
endmodule

bind bpt_monitor bpt_monitor_chk #(
  .OW(OW), .LW(LW), .SW(SW),
  .OVL_LIM(OVL_LIM), .LOSS_LIM(LOSS_LIM), .SETTLE(SETTLE)
) chk (
  .clk(clk), .rst_n(rst_n), .shutdown_en(shutdown_en), .trip_cause(trip_cause),
  .ovl_cnt(ovl_cnt), .bl_cnt(bl_cnt), .tl_cnt(tl_cnt),
  .ovl_cond(ovl_cond), .bl_cond(bl_cond), .tl_cond(tl_cond),
  .settle_cnt(settle_cnt)
);

// File: tb/bpt_monitor_test.sv
`timescale 1ns/1ps
module bpt_monitor_test;
  localparam int OVL = 1000;
  localparam int LOSS = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hard_brake = 1'b0, throttle_open = 1'b0;
  logic brake_present = 1'b1, throttle_present = 1'b1;
  logic shutdown_en;
  logic [1:0] trip_cause;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  bpt_monitor #(.CLK_HZ(1000), .OVERLAP_MS(1000), .LOSS_MS(100), .SETTLE(16)) uut (
    .clk(clk), .rst_n(rst_n), .hard_brake(hard_brake), .throttle_open(throttle_open),
    .brake_present(brake_present), .throttle_present(throttle_present),
    .shutdown_en(shutdown_en), .trip_cause(trip_cause));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic healthy();
    hard_brake = 0; throttle_open = 0; brake_present = 1; throttle_present = 1;
  endtask

  task automatic hold(input logic hb, input logic th, input logic bp, input logic tp, input int n);
    @(negedge clk);
    hard_brake = hb; throttle_open = th; brake_present = bp; throttle_present = tp;
    repeat (n) @(negedge clk);
    healthy();
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (25) @(negedge clk);
  endtask

  task automatic t_powerup();
    healthy();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    check("R6 enable low in reset", shutdown_en, 0);
    check("R7 no cause in reset", trip_cause, 3);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check("R6 enable low in settle window", shutdown_en, 0);
    repeat (10) @(negedge clk);
    check("R6 enable high after settle", shutdown_en, 1);
  endtask

  task automatic t_overlap();
    do_reset();
    hold(1, 1, 1, 1, OVL);
    check("R1 overlap at limit no trip", shutdown_en, 1);
    hold(1, 1, 1, 1, OVL + 1);
    check("R1 R4 overlap past limit trips", shutdown_en, 0);
    check("R7 overlap cause", trip_cause, 0);
    repeat (50) @(negedge clk);
    check("R5 trip held after recovery", shutdown_en, 0);
    hold(1, 1, 0, 1, 2 * LOSS);
    check("R7 cause frozen", trip_cause, 0);
    check("R5 still open", shutdown_en, 0);
    do_reset();
    check("R5 reset clears trip", shutdown_en, 1);
    check("R5 reset clears cause", trip_cause, 3);
  endtask

  task automatic t_brake_loss();
    do_reset();
    hold(0, 0, 0, 1, LOSS);
    check("R2 brake loss at limit no trip", shutdown_en, 1);
    hold(0, 0, 0, 1, LOSS + 1);
    check("R2 brake loss trips", shutdown_en, 0);
    check("R2 R7 brake cause", trip_cause, 1);
  endtask

  task automatic t_throttle_loss();
    do_reset();
    hold(0, 0, 1, 0, LOSS);
    check("R3 throttle loss at limit no trip", shutdown_en, 1);
    hold(0, 0, 1, 0, LOSS + 1);
    check("R3 throttle loss trips", shutdown_en, 0);
    check("R3 R7 throttle cause", trip_cause, 2);
  endtask

  task automatic t_intermittent();
    do_reset();
    @(negedge clk);
    hard_brake = 1; throttle_open = 1;
    repeat (900) @(negedge clk);
    throttle_open = 0;
    @(negedge clk);
    throttle_open = 1;
    repeat (900) @(negedge clk);
    healthy();
    repeat (10) @(negedge clk);
    check("R8 interrupted overlap no trip", shutdown_en, 1);
    check("R8 no cause", trip_cause, 3);
  endtask

  task automatic t_loss_at_powerup();
    healthy();
    brake_present = 0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (25) @(negedge clk);
    check("R6 enable stays low with lost sensor", shutdown_en, 0);
    repeat (100) @(negedge clk);
    check("R2 lost at power-up trips", trip_cause, 1);
    healthy();
    repeat (20) @(negedge clk);
    check("R5 stays open after sensor returns", shutdown_en, 0);
  endtask

  task automatic t_priority();
    do_reset();
    hold(0, 0, 0, 0, 150);
    check("R7 simultaneous losses pick brake", trip_cause, 1);
    check("R4 simultaneous trip opens", shutdown_en, 0);
  endtask

  task automatic t_sync_latency();
    do_reset();
    @(negedge clk);
    brake_present = 0;
    repeat (LOSS + 2) @(negedge clk);
    check("R9 enable still high before pipeline delay", shutdown_en, 1);
    @(negedge clk);
    check("R9 enable low after sync plus timer", shutdown_en, 0);
    healthy();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_powerup();
    t_overlap();
    t_brake_loss();
    t_throttle_loss();
    t_intermittent();
    t_loss_at_powerup();
    t_priority();
    t_sync_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule